// File: doc/BRIEF.md
# Configuration Status Register Bank

This block places a small set of configuration and status registers on an 8-bit, low-bandwidth register bus. The bus has an address, a write enable and write data. Read data comes back through a register one cycle after the address is presented. On the other side, the block gives a core two kinds of register.

A pass-through register hands every bus write straight to the core with a one-cycle strobe. A bus read of it returns whatever value the core is driving at that moment. A bank-held register stores three fields inside the block. Each field has one access rule for the bus side and another for the core side. The bank-held register is 12 bits wide, so it is cut into bus-word slices at consecutive addresses, with the most significant slice first.

Default map:
- Address 0: the pass-through register.
- Address 1: bank-held bits [11:8], in byte bits [3:0]. Byte bits [7:4] read as zero.
- Address 2: bank-held bits [7:0].

Fields of the bank-held register:
- `mode`, bits [11:8]: the bus can read and write it; the core can read and write it.
- `level`, bits [7:4]: the bus can only read it; the core can only write it.
- `cmd`, bits [3:0]: the bus can only write it; the core can only read it.

All fields reset to zero.

Top module: `csr_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it is released, `bus_rdata`, `core_raw_stb`, `core_mode_q` and `core_cmd_q` are all zero. Reads of addresses 1 and 2 return zero until something is written.
- R2: A bus write to address 0 drives `core_raw_stb` high for exactly the following cycle, with `core_raw_wdata` equal to the written byte. Without such a write, `core_raw_stb` stays low.
- R3: A bus read of address 0 returns, in the next cycle, the value on `core_raw_rdata` in the cycle the address was presented. All reads have this one-cycle latency.
- R4: The 12-bit bank-held register is sliced most significant first. Address 1 carries bits [11:8] in byte bits [3:0], with byte bits [7:4] reading as zero. Address 2 carries bits [7:0].
- R5: A bus write to address 1 loads byte bits [3:0] into `mode`. The new value is seen on `core_mode_q`, and in bus reads, from the next cycle on.
- R6: When `core_mode_we` is high in the same cycle as a bus write to address 1, `mode` takes `core_mode_wdata`.
- R7: Bus writes leave `level` unchanged. A `core_level_we` pulse loads `core_level_wdata`, which a bus read of address 2 then shows in byte bits [7:4].
- R8: A bus write to address 2 loads byte bits [3:0] into `cmd`, seen on `core_cmd_q` in the next cycle. Bus reads of address 2 return zero in byte bits [3:0].
- R9: Addresses other than 0, 1 and 2 read as zero. Writes to them change no field and raise no strobe.
- R10: `mode` changes on the core side only in a cycle where `core_mode_we` is high. Otherwise `core_mode_wdata` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register bus word address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Registered read data, one cycle after the address |
| core_raw_wdata | output | 8 | Last byte written to the pass-through register |
| core_raw_stb | output | 1 | One-cycle strobe qualifying `core_raw_wdata` |
| core_raw_rdata | input | 8 | Value a bus read of the pass-through register returns |
| core_mode_q | output | 4 | Current `mode` field |
| core_mode_we | input | 1 | Core write strobe for `mode` |
| core_mode_wdata | input | 4 | Core write data for `mode` |
| core_level_we | input | 1 | Core write strobe for `level` |
| core_level_wdata | input | 4 | Core write data for `level` |
| core_cmd_q | output | 4 | Current `cmd` field |

## Verification
Some properties can be checked on every cycle:
- Every strobe is traced back to a write of address 0, and every such write produces a strobe carrying its byte one cycle later.
- A core write always wins over the bus in the following cycle.
- The bus-read-only field never moves without a core strobe.
- Unmapped addresses and the pass-through address return the expected read data one cycle later.

The bench scenarios are needed for the rest:
- the MSB-first slice placement and the zero padding of the upper slice;
- the masking of the bus-write-only field on reads;
- the reset contents;
- whole sequences of mixed bus and core traffic against a reference model.

// File: rtl/csr_bank_pkg.sv
// Shared access-policy type and helpers for the register bank.
// Assumes: policies are fixed at elaboration time through parameters.
package csr_bank_pkg;

    typedef enum logic [1:0] {
        ACC_RO = 2'd0,
        ACC_WO = 2'd1,
        ACC_RW = 2'd2
    } acc_e;

    // True when the side holding this policy may observe the field.
    function automatic bit can_read(acc_e a);
        return a != ACC_WO;
    endfunction

    // True when the side holding this policy may modify the field.
    function automatic bit can_write(acc_e a);
        return a != ACC_RO;
    endfunction

endpackage

// File: rtl/csr_bank_decode.sv
// Write decoder: turns a bus write into a strobe for the pass-through
// register and a per-bit write mask plus data for the bank-held register.
// Assumes: the bank-held register occupies NSLICE consecutive addresses
// from FREG_BASE, most significant slice at FREG_BASE.
module csr_bank_decode #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int RAW_ADDR  = 0,
    parameter int FREG_BASE = 1,
    parameter int FREG_W    = 12
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              raw_wr,
    output logic [FREG_W-1:0] freg_wmask,
    output logic [FREG_W-1:0] freg_wdata
);
    localparam int NSLICE = (FREG_W + DATA_W - 1) / DATA_W;

    // Pass-through register write select.
    assign raw_wr = bus_we && (bus_addr == ADDR_W'(RAW_ADDR));

    // Each register bit belongs to one slice; slice 0 holds the top bits.
    for (genvar i = 0; i < FREG_W; i++) begin : g_bit
        localparam int SLICE    = NSLICE - 1 - (i / DATA_W);
        localparam int BYTE_BIT = i % DATA_W;
        assign freg_wmask[i] = bus_we && (bus_addr == ADDR_W'(FREG_BASE + SLICE));
        assign freg_wdata[i] = bus_wdata[BYTE_BIT];
    end

endmodule

// File: rtl/csr_bank_raw.sv
// Pass-through register: registers a bus write byte for the core and
// raises a one-cycle strobe in the cycle after the write.
// Assumes: register width equals the bus word width.
module csr_bank_raw #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              stb,
    output logic [DATA_W-1:0] data
);
    // Capture the written byte and pulse the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb  <= 1'b0;
            data <= '0;
        end else begin
            stb <= wr;
            if (wr) data <= wdata;
        end
    end

    // R2: a write yields a strobe carrying its byte one cycle later.
    a_r2_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (stb && data == $past(wdata)));

    // R2: a strobe never appears without a write in the previous cycle.
    a_r2_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> $past(wr));

endmodule

// File: rtl/csr_bank_field.sv
// Bank-held field: stores W bits, accepting masked bus writes and core
// writes according to its two access policies; core write wins a clash.
// Assumes: the bus mask is per bit, so a field may straddle slices.
module csr_bank_field
    import csr_bank_pkg::*;
#(
    parameter int   W       = 4,
    parameter acc_e BUS_ACC = ACC_RW,
    parameter acc_e DEV_ACC = ACC_RW,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_wmask,
    input  logic [W-1:0] bus_wdata,
    input  logic         dev_we,
    input  logic [W-1:0] dev_wdata,
    output logic [W-1:0] q
);
    localparam bit BUS_WR = can_write(BUS_ACC);
    localparam bit DEV_WR = can_write(DEV_ACC);

    logic [W-1:0] nxt;

    // Select the next value: core write over bus write over hold.
    always_comb begin
        nxt = q;
        if (BUS_WR) nxt = (q & ~bus_wmask) | (bus_wdata & bus_wmask);
        if (DEV_WR && dev_we) nxt = dev_wdata;
    end

    // Field storage.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= nxt;
    end

    if (DEV_WR) begin : g_dev_chk
        // R6 / R10: a core strobe always lands its data.
        a_r6_core_wins: assert property (@(posedge clk) disable iff (!rst_n)
            dev_we |=> (q == $past(dev_wdata)));
    end

    if (BUS_WR) begin : g_bus_chk
        // R5: a full-mask bus write lands when the core is quiet.
        a_r5_bus_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (!(DEV_WR && dev_we) && (&bus_wmask)) |=> (q == $past(bus_wdata)));
    end else begin : g_ro_chk
        // R7: bus writes never move a bus-read-only field.
        a_r7_bus_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            !(DEV_WR && dev_we) |=> $stable(q));
    end

endmodule

// File: rtl/csr_bank_rdmux.sv
// Read path: assembles bus words from the pass-through input and the
// bank-held slices and registers the selected word.
// Assumes: freg_rval already has bus-unreadable bits forced to zero.
module csr_bank_rdmux #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int RAW_ADDR  = 0,
    parameter int FREG_BASE = 1,
    parameter int FREG_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] raw_rdata,
    input  logic [FREG_W-1:0] freg_rval,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int NSLICE = (FREG_W + DATA_W - 1) / DATA_W;

    logic [NSLICE-1:0][DATA_W-1:0] slice_word;
    logic [DATA_W-1:0]             rd_nxt;
    logic                          in_map;

    // Build each slice word; bits beyond the register width read as zero.
    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        for (genvar j = 0; j < DATA_W; j++) begin : g_bit
            localparam int IDX = (NSLICE - 1 - k) * DATA_W + j;
            if (IDX < FREG_W) begin : g_live
                assign slice_word[k][j] = freg_rval[IDX];
            end else begin : g_pad
                assign slice_word[k][j] = 1'b0;
            end
        end
    end

    // Pick the word for the presented address; unmapped gives zero.
    always_comb begin
        rd_nxt = '0;
        in_map = (bus_addr == ADDR_W'(RAW_ADDR));
        if (bus_addr == ADDR_W'(RAW_ADDR)) rd_nxt = raw_rdata;
        for (int k = 0; k < NSLICE; k++) begin
            if (bus_addr == ADDR_W'(FREG_BASE + k)) begin
                rd_nxt = slice_word[k];
                in_map = 1'b1;
            end
        end
    end

    // One-cycle registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_nxt;
    end

    // R9: unmapped addresses return zero one cycle later.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_map |=> (bus_rdata == '0));

    // R3: pass-through read returns the core value of the address cycle.
    a_r3_raw_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(RAW_ADDR)) |=> (bus_rdata == $past(raw_rdata)));

endmodule

// File: rtl/csr_bank.sv
// Register bank top: one pass-through register and one bank-held
// register of three fields with separate bus and core access policies.
// Assumes: pass-through width equals DATA_W; field order mode/level/cmd
// from the most significant bit down.
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int RAW_ADDR  = 0,
    parameter int FREG_BASE = 1,
    parameter int MODE_W    = 4,
    parameter int LEVEL_W   = 4,
    parameter int CMD_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [DATA_W-1:0]  core_raw_wdata,
    output logic               core_raw_stb,
    input  logic [DATA_W-1:0]  core_raw_rdata,
    output logic [MODE_W-1:0]  core_mode_q,
    input  logic               core_mode_we,
    input  logic [MODE_W-1:0]  core_mode_wdata,
    input  logic               core_level_we,
    input  logic [LEVEL_W-1:0] core_level_wdata,
    output logic [CMD_W-1:0]   core_cmd_q
);
    localparam int   FREG_W    = MODE_W + LEVEL_W + CMD_W;
    localparam int   CMD_LSB   = 0;
    localparam int   LEVEL_LSB = CMD_W;
    localparam int   MODE_LSB  = CMD_W + LEVEL_W;
    localparam acc_e MODE_BUS  = ACC_RW;
    localparam acc_e MODE_DEV  = ACC_RW;
    localparam acc_e LEVEL_BUS = ACC_RO;
    localparam acc_e LEVEL_DEV = ACC_WO;
    localparam acc_e CMD_BUS   = ACC_WO;
    localparam acc_e CMD_DEV   = ACC_RO;

    logic              raw_wr;
    logic [FREG_W-1:0] freg_wmask;
    logic [FREG_W-1:0] freg_wdata;
    logic [FREG_W-1:0] freg_rval;
    logic [MODE_W-1:0]  mode_q;
    logic [LEVEL_W-1:0] level_q;
    logic [CMD_W-1:0]   cmd_q;

    csr_bank_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAW_ADDR(RAW_ADDR),
        .FREG_BASE(FREG_BASE), .FREG_W(FREG_W)
    ) decode_i (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .raw_wr    (raw_wr),
        .freg_wmask(freg_wmask),
        .freg_wdata(freg_wdata)
    );

    csr_bank_raw #(.DATA_W(DATA_W)) raw_i (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (raw_wr),
        .wdata(bus_wdata),
        .stb  (core_raw_stb),
        .data (core_raw_wdata)
    );

    csr_bank_field #(.W(MODE_W), .BUS_ACC(MODE_BUS), .DEV_ACC(MODE_DEV)) mode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wmask(freg_wmask[MODE_LSB +: MODE_W]),
        .bus_wdata(freg_wdata[MODE_LSB +: MODE_W]),
        .dev_we   (core_mode_we),
        .dev_wdata(core_mode_wdata),
        .q        (mode_q)
    );

    csr_bank_field #(.W(LEVEL_W), .BUS_ACC(LEVEL_BUS), .DEV_ACC(LEVEL_DEV)) level_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wmask(freg_wmask[LEVEL_LSB +: LEVEL_W]),
        .bus_wdata(freg_wdata[LEVEL_LSB +: LEVEL_W]),
        .dev_we   (core_level_we),
        .dev_wdata(core_level_wdata),
        .q        (level_q)
    );

    csr_bank_field #(.W(CMD_W), .BUS_ACC(CMD_BUS), .DEV_ACC(CMD_DEV)) cmd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wmask(freg_wmask[CMD_LSB +: CMD_W]),
        .bus_wdata(freg_wdata[CMD_LSB +: CMD_W]),
        .dev_we   (1'b0),
        .dev_wdata({CMD_W{1'b0}}),
        .q        (cmd_q)
    );

    // Bus view of the register: bus-unreadable fields are forced to zero.
    assign freg_rval = {
        can_read(MODE_BUS)  ? mode_q  : {MODE_W{1'b0}},
        can_read(LEVEL_BUS) ? level_q : {LEVEL_W{1'b0}},
        can_read(CMD_BUS)   ? cmd_q   : {CMD_W{1'b0}}
    };

    // Core view of the core-readable fields.
    assign core_mode_q = mode_q;
    assign core_cmd_q  = cmd_q;

    csr_bank_rdmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAW_ADDR(RAW_ADDR),
        .FREG_BASE(FREG_BASE), .FREG_W(FREG_W)
    ) rdmux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .raw_rdata(core_raw_rdata),
        .freg_rval(freg_rval),
        .bus_rdata(bus_rdata)
    );

endmodule

// File: tb/csr_bank_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared against a reference model of the register map.
module csr_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] core_raw_wdata;
    logic       core_raw_stb;
    logic [7:0] core_raw_rdata;
    logic [3:0] core_mode_q;
    logic       core_mode_we;
    logic [3:0] core_mode_wdata;
    logic       core_level_we;
    logic [3:0] core_level_wdata;
    logic [3:0] core_cmd_q;

    int n_checks = 0;
    int n_errors = 0;
    int cyc      = 0;

    // Reference model state.
    logic [3:0] m_mode, m_level, m_cmd;

    always #5 clk = ~clk;

    csr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_raw_wdata(core_raw_wdata), .core_raw_stb(core_raw_stb),
        .core_raw_rdata(core_raw_rdata), .core_mode_q(core_mode_q),
        .core_mode_we(core_mode_we), .core_mode_wdata(core_mode_wdata),
        .core_level_we(core_level_we), .core_level_wdata(core_level_wdata),
        .core_cmd_q(core_cmd_q)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected bus read word from the model (R3, R4, R7, R8, R9).
    function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [7:0] rawin);
        case (a)
            4'd0:    return rawin;
            4'd1:    return {4'h0, m_mode};
            4'd2:    return {m_level, 4'h0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_req(input logic [3:0] a);
        case (a)
            4'd0:      return "R3";
            4'd1, 4'd2: return "R4";
            default:   return "R9";
        endcase
    endfunction

    // One bus/core cycle, then check every output against the model.
    task automatic step(input logic [3:0] a, input logic we, input logic [7:0] wd,
                        input logic mwe, input logic [3:0] mwd,
                        input logic lwe, input logic [3:0] lwd, input logic [7:0] rawin);
        logic [7:0] e_rd;
        logic       e_stb;
        string      mreq;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd;
        core_mode_we = mwe; core_mode_wdata = mwd;
        core_level_we = lwe; core_level_wdata = lwd;
        core_raw_rdata = rawin;
        e_rd  = exp_read(a, rawin);
        e_stb = we && (a == 4'd0);
        mreq  = (mwe && we && a == 4'd1) ? "R6" : (mwe ? "R10" : "R5");
        if (we && a == 4'd1) m_mode = wd[3:0];
        if (mwe)             m_mode = mwd;
        if (we && a == 4'd2) m_cmd = wd[3:0];
        if (lwe)             m_level = lwd;
        @(posedge clk); #1;
        chk(bus_rdata, e_rd, read_req(a));
        chk({7'd0, core_raw_stb}, {7'd0, e_stb}, "R2");
        if (e_stb) chk(core_raw_wdata, wd, "R2");
        chk({4'h0, core_mode_q}, {4'h0, m_mode}, mreq);
        chk({4'h0, core_cmd_q}, {4'h0, m_cmd}, "R8");
    endtask

    task automatic idle(input logic [3:0] a);
        step(a, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0;
        bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        core_mode_we = 1'b0; core_mode_wdata = '0;
        core_level_we = 1'b0; core_level_wdata = '0; core_raw_rdata = '0;
        m_mode = '0; m_level = '0; m_cmd = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state at the ports.
        chk(bus_rdata, 8'h00, "R1");
        chk({7'd0, core_raw_stb}, 8'h00, "R1");
        chk({4'h0, core_mode_q}, 8'h00, "R1");
        chk({4'h0, core_cmd_q}, 8'h00, "R1");
        @(negedge clk); rst_n = 1'b1;
        idle(4'd1);                         // R1: slice reads are zero
        idle(4'd2);
        // R2: raw write strobe, then no strobe on the next idle cycle.
        step(4'd0, 1'b1, 8'hA5, 1'b0, 4'h0, 1'b0, 4'h0, 8'h11);
        idle(4'd3);
        step(4'd0, 1'b1, 8'h5A, 1'b0, 4'h0, 1'b0, 4'h0, 8'h22);
        step(4'd0, 1'b1, 8'hC3, 1'b0, 4'h0, 1'b0, 4'h0, 8'h33);  // back-to-back
        // R3: raw read returns core value.
        step(4'd0, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h3C);
        // R5, R4: mode write and padded upper slice read.
        step(4'd1, 1'b1, 8'hF7, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00);
        idle(4'd1);
        // R8, R7: cmd written, level ignored; read masks cmd.
        step(4'd2, 1'b1, 8'hAB, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00);
        idle(4'd2);
        // R7: core writes level, bus reads it.
        step(4'd3, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1, 4'h9, 8'h00);
        idle(4'd2);
        // R6: simultaneous bus and core write of mode.
        step(4'd1, 1'b1, 8'h03, 1'b1, 4'hC, 1'b0, 4'h0, 8'h00);
        idle(4'd1);
        // R10: core data without strobe has no effect.
        step(4'd4, 1'b0, 8'h00, 1'b0, 4'hF, 1'b0, 4'h0, 8'h00);
        // R9: unmapped writes and reads.
        step(4'd5, 1'b1, 8'hFF, 1'b0, 4'h0, 1'b0, 4'h0, 8'hEE);
        step(4'd15, 1'b1, 8'h77, 1'b0, 4'h0, 1'b0, 4'h0, 8'hEE);
        idle(4'd1);
        idle(4'd2);
        // Seeded random traffic, mostly in the map.
        begin
            int unsigned seed = 32'hC5A1;
            void'($urandom(seed));
        end
        for (int i = 0; i < 600; i++) begin
            logic [3:0] a;
            a = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 3);
            step(a, 1'($urandom), 8'($urandom),
                 ($urandom % 4) == 0, 4'($urandom),
                 ($urandom % 4) == 0, 4'($urandom), 8'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule